// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches a running calendar clock and raises an alarm interrupt when the time matches a programmed value. A timekeeping block outside it supplies the current time as BCD seconds, minutes, hours, day of month, month and a three-digit year, together with a strobe that pulses for one clock cycle after each seconds update. The block holds one alarm register for each time field and a field-enable register. When the strobe arrives and alarm checking is globally enabled, each enabled field is compared with its current value.

A single matching enabled field is enough to fire the alarm. The fields are ORed together, not ANDed. A match sets a sticky pending flag, and the level interrupt output follows that flag. Software clears the flag by writing a one to it. Registers are written and read through a narrow select/data port. Read data is registered and appears one cycle after the select is presented.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After synchronous reset, all six alarm registers, the enable register and the pending flag are zero, and `alarm_irq` is low.
- R2: A write with `wr_sel` 0 to 5 updates the alarm register for seconds, minutes, hours, day, month or year respectively. The stored value keeps only the low 7, 7, 6, 6, 5 and 12 bits of `wr_data`.
- R3: A comparison happens only on a cycle where `sec_tick` is high and enable bit 6 (global alarm enable) is set. Matches at any other time have no effect.
- R4: Enable bits 0 to 5 select the seconds, minutes, hours, day, month and year comparisons. The alarm fires if at least one selected field equals its current value.
- R5: A field whose enable bit is clear never causes the alarm, even when its value matches.
- R6: The year compares all 12 bits: the low byte holds the tens and units digits, and bits [11:8] hold the hundreds digit. A difference in the hundreds digit alone prevents a match.
- R7: A firing comparison sets the pending flag, which reads as bit 1 of `wr_sel`/`rd_sel` code 7. `alarm_irq` is high from the following cycle.
- R8: A write to code 7 with `wr_data[1]` set clears the pending flag and lowers `alarm_irq` on the next cycle. The same write with `wr_data[1]` clear has no effect.
- R9: A match while the flag is already pending keeps it set. A match and a clear in the same cycle leave the flag set.
- R10: A write with code 6 stores the low 7 bits of `wr_data` into the enable register. `rd_data` returns the register selected by `rd_sel` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse after each seconds update |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_mon | input | 5 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0-5 alarm fields, 6 enable, 7 status |
| wr_data | input | 12 | Write data |
| rd_sel | input | 3 | Read select, same codes as `wr_sel` |
| rd_data | output | 12 | Registered read data |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The hardest case to reach is a match and a clear arriving in the same cycle while the flag is already pending. The outcome depends on the set path taking priority over the write-one-to-clear path. The stimulus first fires the alarm, then drives `sec_tick` and the status clear write on the same clock edge with a still-matching time. Hundreds-digit-only year mismatches and matches on disabled fields are also set up on purpose. This shows that masking and the full 12-bit year compare are not shortcut.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int DATA_W     = 12;
  localparam int SEL_W      = 3;
  localparam int GLOBAL_BIT = 6;
  localparam int PEND_BIT   = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC    = 3'd0,
    SEL_MIN    = 3'd1,
    SEL_HOUR   = 3'd2,
    SEL_DAY    = 3'd3,
    SEL_MON    = 3'd4,
    SEL_YEAR   = 3'd5,
    SEL_ENABLE = 3'd6,
    SEL_STATUS = 3'd7
  } sel_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int W  = 7,
  parameter int DW = 12
) (
  input  logic          en,
  input  logic [DW-1:0] alm,
  input  logic [DW-1:0] cur,
  output logic          hit
);
  always_comb hit = en && (alm[W-1:0] == cur[W-1:0]);
endmodule

// File: rtl/alarm_reg_file.sv
module alarm_reg_file
  import bcd_alarm_pkg::*;
#(
  parameter int          NF      = NUM_FIELDS,
  parameter int          DW      = DATA_W,
  parameter logic [47:0] FW_PACK = 48'h0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [DW-1:0]         wr_data,
  input  logic [SEL_W-1:0]      rd_sel,
  input  logic                  pending,
  output logic [NF-1:0][DW-1:0] alm_q,
  output logic [NF:0]           en_q,
  output logic [DW-1:0]         rd_data
);
  logic [NF-1:0][DW-1:0] wmask;

  for (genvar i = 0; i < NF; i++) begin : g_field
    localparam int W = int'(FW_PACK[i*8 +: 8]);
    assign wmask[i] = DW'((1 << W) - 1);

    always_ff @(posedge clk) begin
      if (rst) alm_q[i] <= '0;
      else if (wr_en && wr_sel == SEL_W'(i)) alm_q[i] <= wr_data & wmask[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (wr_en && wr_sel == SEL_ENABLE) en_q <= wr_data[NF:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        SEL_ENABLE: rd_data <= DW'(en_q);
        SEL_STATUS: rd_data <= DW'({pending, 1'b0});
        default:    rd_data <= alm_q[rd_sel];
      endcase
    end
  end
endmodule

// File: rtl/alarm_pending.sv
module alarm_pending (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic pending
);
  // a new event wins over a simultaneous clear so no alarm is lost
  always_ff @(posedge clk) begin
    if (rst)      pending <= 1'b0;
    else if (set) pending <= 1'b1;
    else if (clr) pending <= 1'b0;
  end
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bcd_alarm_pkg::*;
#(
  parameter int SEC_W  = 7,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 6,
  parameter int MON_W  = 5,
  parameter int YEAR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [MON_W-1:0]  cur_mon,
  input  logic [YEAR_W-1:0] cur_year,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_irq
);
  localparam int NF = NUM_FIELDS;
  localparam int DW = DATA_W;
  localparam logic [47:0] FW_PACK = {8'(YEAR_W), 8'(MON_W), 8'(DAY_W),
                                     8'(HOUR_W), 8'(MIN_W), 8'(SEC_W)};

  logic [NF-1:0][DW-1:0] alm_q;
  logic [NF-1:0][DW-1:0] cur_f;
  logic [NF:0]           mask_q;
  logic [NF-1:0]         hit;
  logic                  any_match;
  logic                  fire;
  logic                  clear_wr;
  logic                  pending;

  assign cur_f[0] = DW'(cur_sec);
  assign cur_f[1] = DW'(cur_min);
  assign cur_f[2] = DW'(cur_hour);
  assign cur_f[3] = DW'(cur_day);
  assign cur_f[4] = DW'(cur_mon);
  assign cur_f[5] = DW'(cur_year);

  alarm_reg_file #(.NF(NF), .DW(DW), .FW_PACK(FW_PACK)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .pending(pending), .alm_q(alm_q), .en_q(mask_q),
    .rd_data(rd_data)
  );

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    alarm_field_cmp #(.W(int'(FW_PACK[i*8 +: 8])), .DW(DW)) u_cmp (
      .en(mask_q[i]), .alm(alm_q[i]), .cur(cur_f[i]), .hit(hit[i])
    );
  end

  assign any_match = |hit;
  assign fire      = sec_tick && mask_q[GLOBAL_BIT] && any_match;
  assign clear_wr  = wr_en && (wr_sel == SEL_STATUS) && wr_data[PEND_BIT];

  alarm_pending u_pend (
    .clk(clk), .rst(rst), .set(fire), .clr(clear_wr), .pending(pending)
  );

  assign alarm_irq = pending;
endmodule

// File: rtl/bcd_alarm_chk.sv
module bcd_alarm_chk
  import bcd_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [NUM_FIELDS:0] mask_q,
  input logic              any_match,
  input logic              alarm_irq
);
  logic do_clr, do_fire;
  assign do_clr  = wr_en && wr_sel == SEL_STATUS && wr_data[PEND_BIT];
  assign do_fire = sec_tick && mask_q[GLOBAL_BIT] && any_match;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !alarm_irq);

  // R3
  no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!alarm_irq && !sec_tick) |=> !alarm_irq);

  // R3
  global_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!alarm_irq && !mask_q[GLOBAL_BIT]) |=> !alarm_irq);

  // R7
  fire_sets_chk: assert property (@(posedge clk) disable iff (rst)
    do_fire |=> alarm_irq);

  // R8
  clear_lowers_chk: assert property (@(posedge clk) disable iff (rst)
    (do_clr && !do_fire) |=> !alarm_irq);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_irq && !do_clr) |=> alarm_irq);
endmodule

bind bcd_alarm_cmp bcd_alarm_chk u_chk (.*);

// File: tb/bcd_alarm_cmp_bench.sv
module bcd_alarm_cmp_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic [6:0]  cur_sec = '0;
  logic [6:0]  cur_min = '0;
  logic [5:0]  cur_hour = '0;
  logic [5:0]  cur_day = '0;
  logic [4:0]  cur_mon = '0;
  logic [11:0] cur_year = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [11:0] rd_data;
  logic        alarm_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";
  bit done = 0;

  int m_alm [6];
  int m_en;
  int m_pend;
  int m_rd;
  int m_irq;

  always #10 clk = ~clk;

  bcd_alarm_cmp u_bcd_alarm_cmp (.*);

  function automatic int cur_of(int i);
    case (i)
      0: return int'(cur_sec);
      1: return int'(cur_min);
      2: return int'(cur_hour);
      3: return int'(cur_day);
      4: return int'(cur_mon);
      default: return int'(cur_year);
    endcase
  endfunction

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    int widths [6];
    bit match;
    widths = '{7, 7, 6, 6, 5, 12};
    if (rst) begin
      foreach (m_alm[i]) m_alm[i] = 0;
      m_en = 0; m_pend = 0; m_rd = 0;
    end else begin
      if (rd_sel == 6) m_rd = m_en;
      else if (rd_sel == 7) m_rd = m_pend * 2;
      else m_rd = m_alm[rd_sel];
      match = 0;
      for (int i = 0; i < 6; i++)
        if (((m_en >> i) & 1) && m_alm[i] == cur_of(i)) match = 1;
      if (sec_tick && ((m_en >> 6) & 1) && match) m_pend = 1;
      else if (wr_en && wr_sel == 7 && wr_data[1]) m_pend = 0;
      if (wr_en) begin
        if (wr_sel < 6) m_alm[wr_sel] = int'(wr_data) % (1 << widths[wr_sel]);
        else if (wr_sel == 6) m_en = int'(wr_data) & 8'h7f;
      end
    end
    m_irq = m_pend;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({phase, " irq"}, int'(alarm_irq), m_irq);
      chk({phase, " rd"}, int'(rd_data), m_rd);
    end
  end

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 12'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int sel, output int val);
    @(negedge clk);
    rd_sel = 3'(sel);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int s = 0; s < 8; s++) begin
      rd(s, v);
      chk("R1", v, 0);
    end
    chk("R1", int'(alarm_irq), 0);

    // R2 width masking on write
    phase = "R2";
    wr(0, 12'hfff); rd(0, v); chk("R2", v, 12'h07f);
    wr(2, 12'hfff); rd(2, v); chk("R2", v, 12'h03f);
    wr(4, 12'hfff); rd(4, v); chk("R2", v, 12'h01f);
    wr(5, 12'habc); rd(5, v); chk("R2", v, 12'habc);
    // R10 enable register
    phase = "R10";
    wr(6, 12'hfff); rd(6, v); chk("R10", v, 12'h07f);
    wr(6, 0);

    // R3 no compare without global enable or without tick
    phase = "R3";
    wr(0, 12'h030);
    cur_sec = 7'h30;
    wr(6, 12'h001);
    tick(); chk("R3", int'(alarm_irq), 0);
    wr(6, 12'h041);
    repeat (3) @(negedge clk);
    chk("R3", int'(alarm_irq), 0);
    // R7 fires on tick
    phase = "R7";
    tick(); chk("R7", int'(alarm_irq), 1);
    rd(7, v); chk("R7", v, 2);

    // R8 clear semantics
    phase = "R8";
    wr(7, 12'h001); chk("R8", int'(alarm_irq), 1);
    wr(7, 12'h002); chk("R8", int'(alarm_irq), 0);

    // R4 OR of fields: seconds mismatch, minutes match
    phase = "R4";
    wr(1, 12'h045);
    cur_min = 7'h45; cur_sec = 7'h31;
    wr(6, 12'h043);
    tick(); chk("R4", int'(alarm_irq), 1);
    wr(7, 12'h002);

    // R5 disabled field match ignored
    phase = "R5";
    wr(3, 12'h017); cur_day = 6'h17;
    wr(6, 12'h041);
    tick(); chk("R5", int'(alarm_irq), 0);

    // R6 year hundreds digit
    phase = "R6";
    wr(5, 12'h125); cur_year = 12'h225;
    wr(6, 12'h060);
    tick(); chk("R6", int'(alarm_irq), 0);
    cur_year = 12'h125;
    tick(); chk("R6", int'(alarm_irq), 1);

    // R9 match while pending, and match with simultaneous clear
    phase = "R9";
    tick(); chk("R9", int'(alarm_irq), 1);
    @(negedge clk);
    sec_tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd7; wr_data = 12'h002;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
    chk("R9", int'(alarm_irq), 1);
    rd(7, v); chk("R9", v, 2);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=finish", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule